// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM with Flow-Through Read

This block is a single-port clocked memory built from four byte lanes. Each lane stores eight data bits and one parity bit, so one word is 36 bits wide. The rising clock edge captures the address, write data, per-lane write strobes, the global write, the chip enable and the address strobe. The read path is flow-through. The word at the held address appears in the same cycle that the edge starts, with no pipeline stage after it. An output enable acts asynchronously on that path. The tri-state bus is modelled as a data bus plus a drive-enable output.

The address strobe selects where the address comes from. When it is low, the cycle either loads the external address (chip enabled) or deselects (chip disabled). When it is high, the cycle keeps the held address and ignores chip enable. The write controls then decide whether the cycle reads or writes.

A small controller runs the cycle state machine. Its states are `CYC_IDLE` (deselected), `CYC_READ` and `CYC_WRITE`. From any state, three transitions are taken on each edge:
- DROP (strobe low, chip disabled) goes to `CYC_IDLE`.
- LOAD (strobe low, chip enabled) captures the external address and goes to `CYC_READ` or `CYC_WRITE`.
- CONTINUE (strobe high) keeps the address and goes to `CYC_READ` or `CYC_WRITE`.

Reset forces `CYC_IDLE`.

Top module: `bytelane_sram`

## Requirements
- R1: Lane 0 holds wdata[7:0] with wpar[0], lane 1 holds wdata[15:8] with wpar[1], lane 2 holds wdata[23:16] with wpar[2], and lane 3 holds wdata[31:24] with wpar[3]. A read returns each lane on the same bit positions.
- R2: An edge with ads_n=0 and ce_n=1 starts a deselected cycle. In that cycle drive_o is 0, nothing is written and the held address does not change.
- R3: An edge with ads_n=0 and ce_n=0 captures addr as the held address. The cycle is a read when no write is requested.
- R4: An edge with ads_n=1 reuses the held address and ignores ce_n. The cycle reads or writes according to the write controls, including after a deselected cycle.
- R5: A write is requested when any bw_n bit is 0 or gw_n is 0. With gw_n=0 all four lanes are stored, whatever bw_n is.
- R6: With gw_n=1, lane k is stored only when bw_n[k]=0. The lanes that are not selected keep their previous contents.
- R7: oe_n is not clocked. During a read cycle drive_o follows ~oe_n at once, without waiting for a clock edge.
- R8: During a write cycle drive_o is 0 whatever the level of oe_n.
- R9: Read data is flow-through: the stored word appears in the same cycle the edge starts. A word written in one cycle is returned by a read of the same address in the next cycle.
- R10: After reset the block is deselected and drive_o is 0 until the first selected read cycle.
- R11: While drive_o is 0, rdata_o and rpar_o are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | 32 | Write data, four lanes of 8 bits |
| wpar_i | input | 4 | Write parity, one bit per lane |
| bw_n_i | input | 4 | Per-lane write strobes, active low |
| gw_n_i | input | 1 | Global write, active low, stores all lanes |
| ce_n_i | input | 1 | Chip enable, active low, sampled only when ads_n_i is low |
| ads_n_i | input | 1 | Address strobe, active low: load or deselect |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 32 | Read data, valid while drive_o is high |
| rpar_o | output | 4 | Read parity, valid while drive_o is high |
| drive_o | output | 1 | Bus drive enable (high = driven, low = high impedance) |

## Verification
The bench builds the block with ADDR_W=4, which gives 16 words. Random addresses therefore hit the same word often. This exercises read-after-write in adjacent cycles, partial-lane merges over data that was written earlier, and reuse of a held address over long runs of strobe-high cycles. The small depth also lets the bench fill every word at the start, so every later read has a known expected value and every lane-mask combination can be reached within a short random run.

// File: rtl/lsram_pkg.sv
package lsram_pkg;
    localparam int unsigned LANES  = 4;
    localparam int unsigned LANE_D = 8;
    localparam int unsigned DATA_W = LANES * LANE_D;
    localparam int unsigned LANE_W = LANE_D + 1;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;
endpackage

// File: rtl/lsram_cycle_ctl.sv
module lsram_cycle_ctl
    import lsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  bw_n_i,
    input  logic              gw_n_i,
    input  logic              ce_n_i,
    input  logic              ads_n_i,
    output cyc_e              cyc_o,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic [LANES-1:0]  we_q_o
);
    cyc_e             state_q;
    cyc_e             state_d;
    logic             wr_req;
    logic             load_ext;
    logic [LANES-1:0] lane_sel;

    // next-state decode: DROP, LOAD, CONTINUE
    always_comb begin
        wr_req   = (~&bw_n_i) | ~gw_n_i;
        lane_sel = gw_n_i ? ~bw_n_i : {LANES{1'b1}};
        load_ext = 1'b0;
        state_d  = state_q;
        unique casez ({ads_n_i, ce_n_i})
            2'b01: begin
                state_d = CYC_IDLE;
            end
            2'b00: begin
                load_ext = 1'b1;
                state_d  = wr_req ? CYC_WRITE : CYC_READ;
            end
            2'b1?: begin
                state_d = wr_req ? CYC_WRITE : CYC_READ;
            end
            default: state_d = CYC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CYC_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs: held address and lane write mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q_o <= '0;
            we_q_o   <= '0;
        end else begin
            if (load_ext) addr_q_o <= addr_i;
            we_q_o <= (state_d == CYC_WRITE) ? lane_sel : '0;
        end
    end

    assign cyc_o = state_q;

    p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_n_i && ce_n_i) |=> (cyc_o == CYC_IDLE && we_q_o == '0));

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_n_i || ce_n_i) |=> $stable(addr_q_o));

    p_gw_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!gw_n_i && !(!ads_n_i && ce_n_i)) |=> (we_q_o == {LANES{1'b1}}));

    p_lane_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n_i && !(!ads_n_i && ce_n_i)) |=> (we_q_o == ~$past(bw_n_i)));
endmodule

// File: rtl/lsram_lane_store.sv
module lsram_lane_store
    import lsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_q_i,
    input  logic [LANES-1:0]  we_q_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LANES-1:0]  wpar_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [LANES-1:0]  rpar_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  wpar_q;

    // write data captured with the cycle, committed on the following edge
    always_ff @(posedge clk) begin
        wdata_q <= wdata_i;
        wpar_q  <= wpar_i;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_word;

        always_ff @(posedge clk) begin
            if (we_q_i[k]) mem[addr_q_i] <= {wpar_q[k], wdata_q[k*LANE_D +: LANE_D]};
        end

        assign rd_word                    = mem[addr_q_i];
        assign rdata_o[k*LANE_D +: LANE_D] = rd_word[LANE_D-1:0];
        assign rpar_o[k]                  = rd_word[LANE_D];
    end
endmodule

// File: rtl/lsram_bus_gate.sv
module lsram_bus_gate
    import lsram_pkg::*;
(
    input  cyc_e              cyc_i,
    input  logic              oe_n_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [LANES-1:0]  rpar_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [LANES-1:0]  rpar_o,
    output logic              drive_o
);
    always_comb begin
        drive_o = (cyc_i == CYC_READ) && !oe_n_i;
        rdata_o = drive_o ? rdata_i : '0;
        rpar_o  = drive_o ? rpar_i  : '0;
    end
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
    import lsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [3:0]        wpar_i,
    input  logic [3:0]        bw_n_i,
    input  logic              gw_n_i,
    input  logic              ce_n_i,
    input  logic              ads_n_i,
    input  logic              oe_n_i,
    output logic [31:0]       rdata_o,
    output logic [3:0]        rpar_o,
    output logic              drive_o
);
    cyc_e              cyc;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  we_q;
    logic [DATA_W-1:0] arr_data;
    logic [LANES-1:0]  arr_par;

    lsram_cycle_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr_i),
        .bw_n_i   (bw_n_i),
        .gw_n_i   (gw_n_i),
        .ce_n_i   (ce_n_i),
        .ads_n_i  (ads_n_i),
        .cyc_o    (cyc),
        .addr_q_o (addr_q),
        .we_q_o   (we_q)
    );

    lsram_lane_store #(.ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .addr_q_i (addr_q),
        .we_q_i   (we_q),
        .wdata_i  (wdata_i),
        .wpar_i   (wpar_i),
        .rdata_o  (arr_data),
        .rpar_o   (arr_par)
    );

    lsram_bus_gate u_gate (
        .cyc_i   (cyc),
        .oe_n_i  (oe_n_i),
        .rdata_i (arr_data),
        .rpar_i  (arr_par),
        .rdata_o (rdata_o),
        .rpar_o  (rpar_o),
        .drive_o (drive_o)
    );

    p_wr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_WRITE) |-> !drive_o);
endmodule

// File: tb/bytelane_sram_tb.sv
`timescale 1ns/1ps
module bytelane_sram_tb;
    localparam int unsigned AW = 4;
    localparam int unsigned DEP = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [3:0]    wpar = '0;
    logic [3:0]    bw_n = 4'hF;
    logic          gw_n = 1'b1;
    logic          ce_n = 1'b1;
    logic          ads_n = 1'b0;
    logic          oe_n = 1'b1;
    logic [31:0]   rdata;
    logic [3:0]    rpar;
    logic          drive;

    int total = 0;
    int bad = 0;

    logic [31:0]   m_d [DEP];
    logic [3:0]    m_p [DEP];
    logic [AW-1:0] m_cur = '0;
    int            m_cyc = 0;   // 0 idle, 1 read, 2 write

    always #2.5 clk = ~clk;

    bytelane_sram #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wpar_i(wpar),
        .bw_n_i(bw_n), .gw_n_i(gw_n), .ce_n_i(ce_n), .ads_n_i(ads_n), .oe_n_i(oe_n),
        .rdata_o(rdata), .rpar_o(rpar), .drive_o(drive)
    );

    task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [36:0] expect_bus(input logic oe);
        logic dr;
        dr = (m_cyc == 1) && !oe;
        return dr ? {1'b1, m_p[m_cur], m_d[m_cur]} : 37'd0;
    endfunction

    // model update at the edge from the sampled inputs
    task automatic model_edge();
        if (!ads_n && ce_n) begin
            m_cyc = 0;
        end else begin
            if (!ads_n) m_cur = addr;
            if (!gw_n || bw_n != 4'hF) begin
                m_cyc = 2;
                for (int k = 0; k < 4; k++) begin
                    if (!gw_n || !bw_n[k]) begin
                        m_d[m_cur][k*8 +: 8] = wdata[k*8 +: 8];
                        m_p[m_cur][k]        = wpar[k];
                    end
                end
            end else begin
                m_cyc = 1;
            end
        end
    endtask

    // called at a negedge: drive, clock, check at next negedge
    task automatic cyc(input string req, input logic a_n, input logic c_n, input logic [AW-1:0] ad,
                       input logic [3:0] b_n, input logic g_n, input logic o_n,
                       input logic [31:0] d, input logic [3:0] p);
        ads_n = a_n; ce_n = c_n; addr = ad; bw_n = b_n; gw_n = g_n; oe_n = o_n;
        wdata = d; wpar = p;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(req, {drive, rpar, rdata}, expect_bus(oe_n));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check("R10 reset", {drive, rpar, rdata}, 37'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", {drive, rpar, rdata}, 37'd0);

        // fill every word with a global write (R3, R5)
        for (int i = 0; i < DEP; i++)
            cyc("R5 fill", 1'b0, 1'b0, AW'(i), 4'hF, 1'b0, 1'b0, $urandom, 4'($urandom));

        // flow-through read of each word (R3, R9)
        for (int i = 0; i < DEP; i++)
            cyc("R9 read fill", 1'b0, 1'b0, AW'(i), 4'hF, 1'b1, 1'b0, 32'h0, 4'h0);

        // single lanes (R1, R6), then readback
        for (int k = 0; k < 4; k++) begin
            cyc("R6 lane write", 1'b0, 1'b0, 4'd5, ~(4'b1 << k), 1'b1, 1'b0,
                32'hA5A5_A5A5 ^ (32'hFF << (8*k)), 4'b1 << k);
            cyc("R1 lane readback", 1'b1, 1'b1, 4'd9, 4'hF, 1'b1, 1'b0, 32'h0, 4'h0);
        end

        // global write overrides strobes held high (R5), read next cycle (R9)
        cyc("R5 gw override", 1'b0, 1'b0, 4'd3, 4'hF, 1'b0, 1'b0, 32'hDEAD_BEEF, 4'hA);
        cyc("R9 rd after wr", 1'b1, 1'b0, 4'd0, 4'hF, 1'b1, 1'b0, 32'h0, 4'h0);
        cyc("R5 gw with strobes", 1'b1, 1'b0, 4'd0, 4'b0110, 1'b0, 1'b0, 32'h1234_5678, 4'h5);
        cyc("R5 gw readback", 1'b1, 1'b0, 4'd0, 4'hF, 1'b1, 1'b0, 32'h0, 4'h0);

        // deselect then reuse with ce_n high (R2, R4); write attempt ignored in deselect
        cyc("R2 deselect", 1'b0, 1'b1, 4'd12, 4'h0, 1'b0, 1'b0, 32'hFFFF_FFFF, 4'hF);
        cyc("R4 reuse after deselect", 1'b1, 1'b1, 4'd12, 4'hF, 1'b1, 1'b0, 32'h0, 4'h0);

        // write cycle with oe low (R8)
        cyc("R8 write quiet", 1'b1, 1'b0, 4'd0, 4'b1110, 1'b1, 1'b0, 32'h0000_0077, 4'h1);
        cyc("R11 read oe high", 1'b1, 1'b0, 4'd0, 4'hF, 1'b1, 1'b1, 32'h0, 4'h0);

        // asynchronous output enable inside one read cycle (R7)
        cyc("R7 read base", 1'b0, 1'b0, 4'd7, 4'hF, 1'b1, 1'b0, 32'h0, 4'h0);
        oe_n = 1'b1; #1;
        check("R7 oe off no clock", {drive, rpar, rdata}, 37'd0);
        oe_n = 1'b0; #1;
        check("R7 oe on no clock", {drive, rpar, rdata}, expect_bus(1'b0));

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic a_n, c_n, g_n, o_n;
            logic [3:0] b_n;
            a_n = ($urandom_range(0, 1) == 1);
            c_n = ($urandom_range(0, 3) == 0);
            g_n = ($urandom_range(0, 7) != 0);
            b_n = ($urandom_range(0, 1) == 1) ? 4'hF : 4'($urandom);
            o_n = ($urandom_range(0, 4) == 0);
            cyc("R4 R6 R9 random", a_n, c_n, AW'($urandom), b_n, g_n, o_n, $urandom, 4'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule